// File: doc/BRIEF.md
# Lock-Protected System Control Register Bank

This block is a memory-mapped bank of status and control words on a simple 32-bit register bus. The bus carries a 12-bit byte address, a read strobe, a write strobe, write data and registered read data. The bank holds several kinds of state:

- a board identifier fixed by a parameter;
- an LED word that drives an output port;
- two free configuration words;
- two flag words that are changed through separate set and clear addresses, one cleared by the block reset and one cleared only by a power-on reset;
- a reset-control word.

The reset-control word can only be changed after software has written a magic key into a lock word. A write to it with the trigger bit set produces a one-cycle system reset request.

Every access completes in a single cycle. There is no back-pressure: the host may issue a read or a write on any cycle. Read data for a read issued at a clock edge appears after that edge and holds until the next read. Offsets that are listed but not modelled return constants or zero. An access to an offset outside the map, or to a non-word-aligned address, is reported on an error pulse.

Top module: `sysreg_bank`

## Requirements
- R1: After the block reset `rst_n`, `led_out`, `rdata`, `sys_reset_req` and `bad_access` are 0. The volatile flags read 3, and the lock and reset-control words read 0.
- R2: A read strobe sampled at a clock edge loads `rdata` with the addressed word at that edge, and `rdata` holds between reads. Offset 0x000 returns the `ID_VALUE` parameter and offset 0x004 returns 0.
- R3: Offset 0x008 is a read/write LED word, and its stored value drives `led_out`.
- R4: A write of exactly 0x0000A05F to the lock word at 0x020 stores 0xA05F. Any other write stores only data bits 14:0, with bit 15 cleared. The lock is open only while the stored word equals 0xA05F.
- R5: Offsets 0x028 and 0x02C are plain read/write configuration words.
- R6: A write to 0x030 ORs the data into the volatile flags, and a write to 0x034 clears every flag bit that is 1 in the data. Reading 0x030 returns the flags.
- R7: Offsets 0x038 (set) and 0x03C (clear) act in the same way on the non-volatile flags, which read at 0x038. These flags are unaffected by `rst_n` and are cleared only by `por_n`.
- R8: A write to the reset-control word at 0x040 takes effect only while the lock is open, and the word reads back at 0x040. An accepted write with data bit 8 set drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R9: Offset 0x044 reads 1, 0x050 reads 0x1000, 0x084 reads 0x02000000 and 0x088 reads 0xFF000000. All other listed offsets (0x00C–0x01C, 0x024, 0x048–0x04C, 0x054–0x074, 0x080–0x09C, 0x0C0–0x0D0) read 0, and writes to any of these read-only offsets change nothing.
- R10: An access to an address that is not word-aligned, or to an offset outside the listed map (for example 0x078, 0x0A0, 0x0D4), reads 0 and changes no state. It also drives `bad_access` high for the one cycle after the access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for the non-volatile flags, active low |
| addr | input | 12 | Byte address within the 4 KB window |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| led_out | output | 32 | LED word |
| sys_reset_req | output | 1 | One-cycle system reset request |
| bad_access | output | 1 | One-cycle unmapped or misaligned access flag |

## Verification
The set/clear flag logic is driven with data that overlaps the existing bits and with data that does not. This separates a correct OR/AND-NOT update from a plain overwrite.

The lock is tried with the exact key, with a word whose low half holds the key but whose upper bits are nonzero, and with a value that has bit 15 set. These cases separate full-word key matching from a partial match and check that bit 15 is masked.

Reset-control writes are issued both locked and unlocked, with and without bit 8. This checks that the request pulse appears only for an accepted trigger and lasts one cycle.

The two resets are applied separately, to show that only the power-on reset clears the non-volatile flags.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;

  // byte offsets with behaviour attached
  localparam logic [ADDR_W-1:0] OFF_ID     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SW     = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_LED    = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CFG0   = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_CFG1   = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_FSET   = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_FCLR   = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_NVSET  = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_NVCLR  = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_RSTCTL = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_BUSCTL = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_DISP   = 12'h050;
  localparam logic [ADDR_W-1:0] OFF_CORE0  = 12'h084;
  localparam logic [ADDR_W-1:0] OFF_CORE1  = 12'h088;

  localparam logic [DATA_W-1:0] VAL_BUSCTL = 32'h0000_0001;
  localparam logic [DATA_W-1:0] VAL_DISP   = 32'h0000_1000;
  localparam logic [DATA_W-1:0] VAL_CORE0  = 32'h0200_0000;
  localparam logic [DATA_W-1:0] VAL_CORE1  = 32'hFF00_0000;

  // mapped word-index ranges (inclusive)
  localparam int NUM_RANGES = 3;
  localparam int RANGE_LO [NUM_RANGES] = '{0, 32, 48};
  localparam int RANGE_HI [NUM_RANGES] = '{29, 39, 52};

  typedef struct packed {
    logic led;
    logic lock;
    logic cfg0;
    logic cfg1;
    logic fset;
    logic fclr;
    logic nvset;
    logic nvclr;
    logic rstctl;
  } wr_sel_t;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output wr_sel_t           wsel
);
  localparam int RW = IDX_W;

  logic [RW-1:0]         idx;
  logic [NUM_RANGES-1:0] in_range;

  assign idx = addr[ADDR_W-1:2];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
    assign in_range[g] = (int'(idx) >= RANGE_LO[g]) && (int'(idx) <= RANGE_HI[g]);
  end

  assign hit = (addr[1:0] == 2'b00) && (|in_range);

  always_comb begin
    wsel        = '0;
    wsel.led    = wr && hit && (addr == OFF_LED);
    wsel.lock   = wr && hit && (addr == OFF_LOCK);
    wsel.cfg0   = wr && hit && (addr == OFF_CFG0);
    wsel.cfg1   = wr && hit && (addr == OFF_CFG1);
    wsel.fset   = wr && hit && (addr == OFF_FSET);
    wsel.fclr   = wr && hit && (addr == OFF_FCLR);
    wsel.nvset  = wr && hit && (addr == OFF_NVSET);
    wsel.nvclr  = wr && hit && (addr == OFF_NVCLR);
    wsel.rstctl = wr && hit && (addr == OFF_RSTCTL);
  end

  // R10: no write select may fire without a decode hit
  always_comb begin
    if (!hit) a_r10_no_sel_on_miss: assert (wsel == '0);
  end
endmodule

// File: rtl/sysreg_lock.sv
module sysreg_lock #(
  parameter int          W   = 16,
  parameter logic [W-1:0] KEY = 16'hA05F,
  parameter int          DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic [DW-1:0] data,
  output logic [W-1:0]  q,
  output logic          open
);
  localparam logic [DW-1:0] KEY_WIDE = DW'(KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (wen) begin
      if (data == KEY_WIDE)
        q <= KEY;
      else
        q <= {1'b0, data[W-2:0]};
    end
  end

  assign open = (q == KEY);

  // R4: the top bit can only be set by storing the exact key
  a_r4_top_bit_only_key: assert property (@(posedge clk) disable iff (!rst_n)
    q[W-1] |-> (q == KEY));

  // R4: a non-key write always leaves the lock closed
  a_r4_nonkey_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && data != KEY_WIDE) |=> !open);
endmodule

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      q <= RST_VAL;
    else if (set_en)
      q <= q | data;
    else if (clr_en)
      q <= q & ~data;
  end

  // R6/R7: a set leaves every data bit high
  a_r6_set_bits_high: assert property (@(posedge clk) disable iff (!arst_n)
    set_en |=> ((q & $past(data)) == $past(data)));

  // R6/R7: a clear leaves every data bit low
  a_r6_clr_bits_low: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_en && !set_en) |=> ((q & $past(data)) == '0));

  // R7: with no strobe the word holds
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!arst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h4178_0500,
  parameter logic [15:0] LOCK_KEY = 16'hA05F,
  parameter logic [31:0] FLAGS_RST = 32'h0000_0003,
  parameter int          TRIG_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic [11:0] addr,
  input  logic        rd,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] led_out,
  output logic        sys_reset_req,
  output logic        bad_access
);
  localparam int LOCK_W = $bits(LOCK_KEY);

  logic              hit;
  wr_sel_t           wsel;
  logic [LOCK_W-1:0] lock_q;
  logic              lock_open;
  logic [31:0]       led_q, cfg0_q, cfg1_q, flags_q, nv_q, rstctl_q;
  logic [31:0]       rd_val;
  logic              rst_accept;

  sysreg_decode u_dec (
    .addr (addr),
    .wr   (wr),
    .hit  (hit),
    .wsel (wsel)
  );

  sysreg_lock #(.W(LOCK_W), .KEY(LOCK_KEY), .DW(DATA_W)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .wen   (wsel.lock),
    .data  (wdata),
    .q     (lock_q),
    .open  (lock_open)
  );

  sysreg_setclr #(.W(DATA_W), .RST_VAL(FLAGS_RST)) u_flags (
    .clk    (clk),
    .arst_n (rst_n),
    .set_en (wsel.fset),
    .clr_en (wsel.fclr),
    .data   (wdata),
    .q      (flags_q)
  );

  sysreg_setclr #(.W(DATA_W), .RST_VAL('0)) u_nvflags (
    .clk    (clk),
    .arst_n (por_n),
    .set_en (wsel.nvset),
    .clr_en (wsel.nvclr),
    .data   (wdata),
    .q      (nv_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else begin
      if (wsel.led)  led_q  <= wdata;
      if (wsel.cfg0) cfg0_q <= wdata;
      if (wsel.cfg1) cfg1_q <= wdata;
    end
  end

  assign rst_accept = wsel.rstctl && lock_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstctl_q      <= '0;
      sys_reset_req <= 1'b0;
    end else begin
      if (rst_accept) rstctl_q <= wdata;
      sys_reset_req <= rst_accept && wdata[TRIG_BIT];
    end
  end

  always_comb begin
    unique case (addr)
      OFF_ID:     rd_val = ID_VALUE;
      OFF_SW:     rd_val = '0;
      OFF_LED:    rd_val = led_q;
      OFF_LOCK:   rd_val = 32'(lock_q);
      OFF_CFG0:   rd_val = cfg0_q;
      OFF_CFG1:   rd_val = cfg1_q;
      OFF_FSET:   rd_val = flags_q;
      OFF_NVSET:  rd_val = nv_q;
      OFF_RSTCTL: rd_val = rstctl_q;
      OFF_BUSCTL: rd_val = VAL_BUSCTL;
      OFF_DISP:   rd_val = VAL_DISP;
      OFF_CORE0:  rd_val = VAL_CORE0;
      OFF_CORE1:  rd_val = VAL_CORE1;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      if (rd) rdata <= hit ? rd_val : '0;
      bad_access <= (rd || wr) && !hit;
    end
  end

  assign led_out = led_q;

  // R8: a closed lock leaves reset control untouched
  a_r8_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel.rstctl && !lock_open) |=> $stable(rstctl_q));

  // R8: a request always coincides with a stored trigger bit
  a_r8_req_has_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> rstctl_q[TRIG_BIT]);

  // R10: an unmapped write leaves the plain words unchanged
  a_r10_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> ($stable(led_q) && $stable(cfg0_q) && $stable(cfg1_q)));

  // R10: an unmapped read returns zero
  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (rdata == '0 && bad_access));

  // R2: read data holds when no read is issued
  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;
  localparam logic [31:0] ID = 32'h1234_5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic [11:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, led_out;
  logic        sys_reset_req, bad_access;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysreg_bank #(.ID_VALUE(ID)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_n         (por_n),
    .addr          (addr),
    .rd            (rd),
    .wr            (wr),
    .wdata         (wdata),
    .rdata         (rdata),
    .led_out       (led_out),
    .sys_reset_req (sys_reset_req),
    .bad_access    (bad_access)
  );

  typedef struct packed {
    logic        is_rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, ID,            4'd2},  // R2 identifier
    '{1'b1, 12'h004, 32'h0,         4'd2},  // R2 switches
    '{1'b0, 12'h008, 32'h0000_00A5, 4'd3},  // R3
    '{1'b1, 12'h008, 32'h0000_00A5, 4'd3},
    '{1'b0, 12'h028, 32'hDEAD_BEEF, 4'd5},  // R5
    '{1'b1, 12'h028, 32'hDEAD_BEEF, 4'd5},
    '{1'b0, 12'h02C, 32'h1234_5678, 4'd5},
    '{1'b1, 12'h02C, 32'h1234_5678, 4'd5},
    '{1'b1, 12'h030, 32'h3,         4'd6},  // R6 reset value
    '{1'b0, 12'h030, 32'hF1,        4'd6},
    '{1'b1, 12'h030, 32'hF3,        4'd6},
    '{1'b0, 12'h034, 32'h11,        4'd6},
    '{1'b1, 12'h030, 32'hE2,        4'd6},
    '{1'b0, 12'h038, 32'h0F,        4'd7},  // R7
    '{1'b1, 12'h038, 32'h0F,        4'd7},
    '{1'b0, 12'h03C, 32'h05,        4'd7},
    '{1'b1, 12'h038, 32'h0A,        4'd7},
    '{1'b0, 12'h020, 32'h1234_ABCD, 4'd4},  // R4 masked
    '{1'b1, 12'h020, 32'h2BCD,      4'd4},
    '{1'b0, 12'h020, 32'h0001_A05F, 4'd4},  // R4 key plus upper bits
    '{1'b1, 12'h020, 32'h205F,      4'd4},
    '{1'b0, 12'h040, 32'h55,        4'd8},  // R8 locked
    '{1'b1, 12'h040, 32'h0,         4'd8},
    '{1'b0, 12'h020, 32'h0000_A05F, 4'd4},  // R4 key
    '{1'b1, 12'h020, 32'hA05F,      4'd4},
    '{1'b0, 12'h040, 32'h77,        4'd8},  // R8 unlocked
    '{1'b1, 12'h040, 32'h77,        4'd8},
    '{1'b1, 12'h044, 32'h1,         4'd9},  // R9
    '{1'b1, 12'h050, 32'h1000,      4'd9},
    '{1'b1, 12'h084, 32'h0200_0000, 4'd9},
    '{1'b1, 12'h088, 32'hFF00_0000, 4'd9},
    '{1'b0, 12'h044, 32'hFFFF_FFFF, 4'd9},
    '{1'b1, 12'h044, 32'h1,         4'd9},
    '{1'b1, 12'h0C0, 32'h0,         4'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, the block samples at the next rising edge,
  // and registered results are visible at the falling edge after that
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 led_out", led_out, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    check("R1 sys_reset_req", {31'h0, sys_reset_req}, 32'h0);
    check("R1 bad_access", {31'h0, bad_access}, 32'h0);
    bus_rd(12'h020); check("R1 lock", rdata, 32'h0);
    bus_rd(12'h040); check("R1 rstctl", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        bus_rd(VEC[i].a);
        check($sformatf("R%0d table read %h", VEC[i].req, VEC[i].a), rdata, VEC[i].d);
      end else begin
        bus_wr(VEC[i].a, VEC[i].d);
      end
    end

    // R3 output port follows the register
    check("R3 led_out", led_out, 32'h0000_00A5);

    // R2 rdata holds with no read strobe
    @(negedge clk); @(negedge clk);
    check("R2 hold", rdata, 32'h0);

    // R8 trigger pulse (lock is open)
    bus_wr(12'h040, 32'h0000_0100);
    check("R8 pulse high", {31'h0, sys_reset_req}, 32'h1);
    @(negedge clk);
    check("R8 pulse single", {31'h0, sys_reset_req}, 32'h0);
    bus_wr(12'h040, 32'h0000_0003);
    check("R8 no trigger bit", {31'h0, sys_reset_req}, 32'h0);
    bus_wr(12'h020, 32'h0);
    bus_wr(12'h040, 32'h0000_0100);
    check("R8 locked no pulse", {31'h0, sys_reset_req}, 32'h0);
    bus_rd(12'h040);
    check("R8 locked value kept", rdata, 32'h0000_0003);

    // R10 unmapped and misaligned accesses
    bus_rd(12'h078);
    check("R10 unmapped read flag", {31'h0, bad_access}, 32'h1);
    check("R10 unmapped read data", rdata, 32'h0);
    @(negedge clk);
    check("R10 flag single", {31'h0, bad_access}, 32'h0);
    bus_wr(12'h009, 32'h0000_00FF);
    check("R10 misaligned flag", {31'h0, bad_access}, 32'h1);
    check("R10 misaligned no effect", led_out, 32'h0000_00A5);
    bus_wr(12'h0D4, 32'h0000_0001);
    check("R10 high offset flag", {31'h0, bad_access}, 32'h1);
    bus_rd(12'h0A0);
    check("R10 gap read", rdata, 32'h0);
    bus_rd(12'h00C);
    check("R9 mapped no flag", {31'h0, bad_access}, 32'h0);

    // R7 block reset keeps the non-volatile flags
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 led after reset", led_out, 32'h0);
    bus_rd(12'h030); check("R1 flags after reset", rdata, 32'h3);
    bus_rd(12'h038); check("R7 nv survives rst_n", rdata, 32'h0A);
    bus_rd(12'h028); check("R1 cfg after reset", rdata, 32'h0);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    bus_rd(12'h038); check("R7 nv cleared by por_n", rdata, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule